// File: doc/BRIEF.md
# HART transmit framing sequencer

This block sits between a host that supplies transmit bytes and the FSK modulator of a HART modem. The host writes bytes into a small transmit FIFO. It raises RTS to ask for the line. The block answers with CTS and a carrier enable, and from that clock on it drives a single bit stream into the modulator: logic 1 for mark, logic 0 for space. Each byte becomes an 11-bit asynchronous character, and an external single-cycle baud tick paces the bits.

When the FIFO is empty at the moment CTS rises, the line carries plain mark. A saturating counter of completed mark bit times lets the host wait until the receiver has seen enough carrier before it sends its preamble. When the FIFO was filled beforehand, the first character starts on the CTS cycle with no mark lead-in. If the FIFO runs dry between characters while RTS is still held, the block fills the gap with mark and raises a sticky underrun flag. When RTS is released, the character in flight is completed before CTS drops. Bytes still queued are kept. The host watches the FIFO level to refill it in time.

Top module: `hart_tx_seq`

## Requirements
- R1: After reset, cts and carrier_en are 0, tx_bit is 1 (mark), fifo_level is 0, underrun and overflow are 0 and mark_count is 0.
- R2: When rts is high while the link is idle, cts and carrier_en both rise at the next clock edge and stay high together until the link is released.
- R3: If the FIFO is empty when cts rises, tx_bit is 1. mark_count is cleared when cts rises, then increments by one on each baud tick that ends a mark bit time, saturating at 2^MARK_W-1 (15 by default).
- R4: If the FIFO holds data when cts rises, the first queued byte is popped at that same edge and tx_bit shows its start bit (0) in the first cycle that cts is high.
- R5: A character is 11 bit times. Bit position 0 is the start bit (0). Positions 1 to 8 carry data bits 0 to 7, LSB first. Position 9 is odd parity, so that the eight data bits plus the parity bit hold an odd number of ones. Position 10 is the stop bit (1). Each position holds until the next baud tick. When a byte is queued, the next character's start bit follows the stop bit with no gap.
- R6: A byte written while the line is sending mark under cts is loaded at the next baud tick: tx_bit stays 1 until that tick and shows the start bit right after it.
- R7: If a character's stop bit ends while rts is high and the FIFO is empty, tx_bit returns to mark and underrun is set. underrun stays set until a flag_clr pulse. A set in the same cycle as a clear wins.
- R8: When rts goes low during a character, the character completes. cts and carrier_en fall at the edge of the baud tick that ends its stop bit, and bytes still in the FIFO are kept. When rts goes low during mark, cts falls at the next edge.
- R9: The FIFO holds DEPTH bytes (16 by default) and fifo_level reports how many are stored. A write while the FIFO is full is dropped and sets a sticky overflow flag, which flag_clr clears.
- R10: While cts is low, baud_tick has no effect: tx_bit stays 1, fifo_level and mark_count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one transmit byte |
| wr_data | input | 8 | Byte to queue |
| rts | input | 1 | Host request to transmit |
| baud_tick | input | 1 | Single-cycle pulse marking the end of one bit time |
| flag_clr | input | 1 | Clears the underrun and overflow flags |
| tx_bit | output | 1 | Current line bit to the modulator (1 mark, 0 space) |
| carrier_en | output | 1 | Modulator carrier enable |
| cts | output | 1 | Clear-to-send answer to the host |
| fifo_level | output | $clog2(DEPTH+1) | Bytes currently queued |
| underrun | output | 1 | Sticky flag: FIFO ran dry between characters while rts was held |
| overflow | output | 1 | Sticky flag: a write hit a full FIFO |
| mark_count | output | MARK_W | Saturating count of mark bit times since cts rose |

## Verification
The framing is swept over all 256 byte values. Each value goes through the FIFO and is compared bit by bit against a frame built in the bench, in bursts of sixteen back-to-back characters, so parity, bit order and the gapless hand-over between characters are each tested. Separate runs start the link with an empty FIFO and with a preloaded one, which separates the mark lead-in with its counter saturation from the immediate start bit. One byte arrives during mark to show loading on the tick boundary. A release of rts in the middle of a character shows the completion rule and that the queued bytes are kept. The FIFO is filled to its limit plus one to show the drop and the overflow flag, and baud ticks sent while idle show that they have no effect.

// File: rtl/hart_tx_pkg.sv
package hart_tx_pkg;

    localparam int FRAME_BITS = 11;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int DEF_DEPTH  = 16;
    localparam int DEF_MARK_W = 4;

    typedef enum logic {
        LINK_IDLE = 1'b0,
        LINK_ON   = 1'b1
    } link_state_e;

    typedef struct packed {
        link_state_e            st;
        logic                   busy;
        logic [IDX_W-1:0]       idx;
        logic [FRAME_BITS-1:0]  frame;
    } ser_regs_t;

    // Frame layout, bit 0 leaves first: start, data LSB first, odd parity, stop
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] d);
        return {1'b1, ~(^d), d, 1'b0};
    endfunction

endpackage

// File: rtl/hart_tx_fifo.sv
module hart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             wr_drop
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
    logic             wr_ok, rd_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign wr_drop = wr_en && full;
    assign rd_data = mem[rd_ptr];

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign wr_ptr_nx = wr_ptr + 1'b1;
            assign rd_ptr_nx = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr_nx;
            if (rd_ok) rd_ptr <= rd_ptr_nx;
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/hart_tx_ser.sv
module hart_tx_ser
    import hart_tx_pkg::*;
#(
    parameter int MARK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rts,
    input  logic              baud_tick,
    input  logic              flag_clr,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_data,
    output logic              pop,
    output logic              tx_bit,
    output logic              cts,
    output logic [MARK_W-1:0] mark_count,
    output logic              underrun
);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [MARK_W-1:0] MARK_MAX = {MARK_W{1'b1}};

    ser_regs_t         cur, nxt;
    logic [MARK_W-1:0] mark_q, mark_d;
    logic              under_q;
    logic              last_bit, slot_end, under_set;

    assign last_bit  = cur.busy && (cur.idx == LAST_IDX);
    assign slot_end  = baud_tick && (!cur.busy || last_bit);
    assign under_set = (cur.st == LINK_ON) && rts && baud_tick && last_bit && fifo_empty;

    always_comb begin
        nxt    = cur;
        mark_d = mark_q;
        pop    = 1'b0;
        case (cur.st)
            LINK_IDLE: begin
                if (rts) begin
                    nxt.st   = LINK_ON;
                    nxt.idx  = '0;
                    nxt.busy = !fifo_empty;
                    mark_d   = '0;
                    if (!fifo_empty) begin
                        pop       = 1'b1;
                        nxt.frame = build_frame(fifo_data);
                    end
                end
            end
            default: begin
                if (!rts && (!cur.busy || (baud_tick && last_bit))) begin
                    nxt.st   = LINK_IDLE;
                    nxt.busy = 1'b0;
                    nxt.idx  = '0;
                end else if (cur.busy && baud_tick && !last_bit) begin
                    nxt.idx = cur.idx + 1'b1;
                end else if (slot_end) begin
                    if (!cur.busy && mark_q != MARK_MAX) begin
                        mark_d = mark_q + 1'b1;
                    end
                    nxt.idx  = '0;
                    nxt.busy = !fifo_empty;
                    if (!fifo_empty) begin
                        pop       = 1'b1;
                        nxt.frame = build_frame(fifo_data);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '{st: LINK_IDLE, busy: 1'b0, idx: '0, frame: '1};
            mark_q  <= '0;
            under_q <= 1'b0;
        end else begin
            cur    <= nxt;
            mark_q <= mark_d;
            if (under_set)     under_q <= 1'b1;
            else if (flag_clr) under_q <= 1'b0;
        end
    end

    assign tx_bit     = cur.busy ? cur.frame[cur.idx] : 1'b1;
    assign cts        = (cur.st == LINK_ON);
    assign mark_count = mark_q;
    assign underrun   = under_q;

endmodule

// File: rtl/hart_tx_seq.sv
module hart_tx_seq
    import hart_tx_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int MARK_W = DEF_MARK_W,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rts,
    input  logic              baud_tick,
    input  logic              flag_clr,
    output logic              tx_bit,
    output logic              carrier_en,
    output logic              cts,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              underrun,
    output logic              overflow,
    output logic [MARK_W-1:0] mark_count
);
    logic       pop, f_full, f_empty, f_drop, ser_cts;
    logic [7:0] f_data;
    logic       ovf_q;

    hart_tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (f_data),
        .level   (fifo_level),
        .full    (f_full),
        .empty   (f_empty),
        .wr_drop (f_drop)
    );

    hart_tx_ser #(.MARK_W(MARK_W)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .rts        (rts),
        .baud_tick  (baud_tick),
        .flag_clr   (flag_clr),
        .fifo_empty (f_empty),
        .fifo_data  (f_data),
        .pop        (pop),
        .tx_bit     (tx_bit),
        .cts        (ser_cts),
        .mark_count (mark_count),
        .underrun   (underrun)
    );

    always_ff @(posedge clk) begin
        if (rst)           ovf_q <= 1'b0;
        else if (f_drop)   ovf_q <= 1'b1;
        else if (flag_clr) ovf_q <= 1'b0;
    end

    assign overflow   = ovf_q;
    assign cts        = ser_cts;
    assign carrier_en = ser_cts;

    logic unused_full;
    assign unused_full = f_full;

endmodule

// File: rtl/hart_tx_seq_chk.sv
module hart_tx_seq_chk #(
    parameter int DEPTH  = 16,
    parameter int MARK_W = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              rts,
    input logic              baud_tick,
    input logic              flag_clr,
    input logic              tx_bit,
    input logic              carrier_en,
    input logic              cts,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              underrun,
    input logic              overflow,
    input logic [MARK_W-1:0] mark_count
);
    a_r2_cts_needs_rts: assert property (@(posedge clk) disable iff (rst)
        $rose(cts) |-> $past(rts));

    a_r3_mark_on_empty_start: assert property (@(posedge clk) disable iff (rst)
        $rose(cts) && ($past(fifo_level) == '0) |-> tx_bit);

    a_r3_count_cleared: assert property (@(posedge clk) disable iff (rst)
        $rose(cts) |-> (mark_count == '0));

    a_r4_start_on_preload: assert property (@(posedge clk) disable iff (rst)
        $rose(cts) && ($past(fifo_level) != '0) |-> !tx_bit);

    a_r5_bit_holds_between_ticks: assert property (@(posedge clk) disable iff (rst)
        cts && $past(cts) && !$past(baud_tick) |-> $stable(tx_bit));

    a_r7_underrun_while_held: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(rts) && $past(cts));

    a_r8_idle_line_marks: assert property (@(posedge clk) disable iff (rst)
        !cts |-> tx_bit && !carrier_en);

    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVL_W'(DEPTH));

    a_r9_full_write_flags: assert property (@(posedge clk) disable iff (rst)
        wr_en && (fifo_level == LVL_W'(DEPTH)) |=> overflow && (fifo_level != '0));

    a_r10_idle_level_kept: assert property (@(posedge clk) disable iff (rst)
        !cts && !rts && !wr_en |=> $stable(fifo_level));

    logic unused_chk;
    assign unused_chk = ^wr_data;

endmodule

bind hart_tx_seq hart_tx_seq_chk #(.DEPTH(DEPTH), .MARK_W(MARK_W)) u_chk (.*);

// File: tb/hart_tx_seq_test.sv
module hart_tx_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rts = 1'b0;
    logic       baud_tick = 1'b0;
    logic       flag_clr = 1'b0;
    logic       tx_bit, carrier_en, cts, underrun, overflow;
    logic [4:0] fifo_level;
    logic [3:0] mark_count;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hart_tx_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rts(rts),
        .baud_tick(baud_tick), .flag_clr(flag_clr), .tx_bit(tx_bit),
        .carrier_en(carrier_en), .cts(cts), .fifo_level(fifo_level),
        .underrun(underrun), .overflow(overflow), .mark_count(mark_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input logic [7:0] b, input int k);
        if (k == 0) return 1'b0;
        if (k <= 8) return b[k-1];
        if (k == 9) return ~(^b);
        return 1'b1;
    endfunction

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; rts = 0; baud_tick = 0; flag_clr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick();
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int errs;
        logic [7:0] b;
        do_reset();
        // R1 reset state
        chk(cts == 0 && carrier_en == 0, "R1 cts/carrier", cts, 0);
        chk(tx_bit == 1, "R1 tx_bit", tx_bit, 1);
        chk(fifo_level == 0 && mark_count == 0, "R1 level/count", fifo_level, 0);
        chk(underrun == 0 && overflow == 0, "R1 flags", underrun + overflow, 0);

        // R10 ticks while idle do nothing
        push(8'h11);
        repeat (3) tick();
        chk(tx_bit == 1 && cts == 0, "R10 idle tick line", tx_bit, 1);
        chk(fifo_level == 1 && mark_count == 0, "R10 idle tick level", fifo_level, 1);

        // R2/R3 empty start, mark and counter saturation
        do_reset();
        rts = 1'b1;
        @(negedge clk);
        chk(cts == 1 && carrier_en == 1, "R2 cts and carrier rise", cts, 1);
        chk(tx_bit == 1 && mark_count == 0, "R3 mark at start", tx_bit, 1);
        for (int k = 1; k <= 17; k++) begin
            tick();
            chk(mark_count == ((k > 15) ? 15 : k) && tx_bit == 1, "R3 mark count",
                mark_count, (k > 15) ? 15 : k);
        end

        // R6 byte arriving during mark loads on the next tick
        push(8'hA5);
        chk(fifo_level == 1 && tx_bit == 1, "R6 wait for tick", tx_bit, 1);
        tick();
        chk(tx_bit == 0 && fifo_level == 0, "R6 start after tick", tx_bit, 0);
        errs = 0;
        for (int k = 0; k <= 10; k++) begin
            if (tx_bit !== exp_bit(8'hA5, k)) errs++;
            tick();
        end
        chk(errs == 0, "R5 frame of A5", errs, 0);
        // R7 underrun on dry FIFO with rts held
        chk(underrun == 1 && tx_bit == 1, "R7 underrun set", underrun, 1);
        chk(cts == 1, "R2 cts held", cts, 1);
        pulse_clr();
        chk(underrun == 0, "R7 flag cleared", underrun, 0);
        rts = 1'b0;
        @(negedge clk);
        chk(cts == 0 && carrier_en == 0, "R8 drop during mark", cts, 0);

        // R8 rts release mid-character, queued byte kept
        do_reset();
        push(8'h3C);
        push(8'h81);
        rts = 1'b1;
        @(negedge clk);
        chk(cts == 1 && tx_bit == 0 && fifo_level == 1, "R4 immediate start", tx_bit, 0);
        errs = 0;
        for (int k = 0; k <= 10; k++) begin
            if (k == 3) rts = 1'b0;
            if (tx_bit !== exp_bit(8'h3C, k) || cts !== 1) errs++;
            tick();
        end
        chk(errs == 0, "R8 character completed", errs, 0);
        chk(cts == 0 && carrier_en == 0, "R8 cts falls after stop", cts, 0);
        chk(fifo_level == 1 && underrun == 0, "R8 queue kept", fifo_level, 1);

        // R9 overflow, then R4/R5 sweep over all byte values
        do_reset();
        for (int i = 0; i < 16; i++) push(8'(i));
        chk(fifo_level == 16 && overflow == 0, "R9 full level", fifo_level, 16);
        push(8'hFF);
        chk(fifo_level == 16 && overflow == 1, "R9 dropped write", overflow, 1);
        pulse_clr();
        chk(overflow == 0, "R9 overflow cleared", overflow, 0);
        for (int c = 0; c < 16; c++) begin
            if (c > 0) begin
                for (int i = 0; i < 16; i++) push(8'(c * 16 + i));
            end
            rts = 1'b1;
            @(negedge clk);
            chk(cts == 1 && tx_bit == 0, "R4 preload start", tx_bit, 0);
            for (int j = 0; j < 16; j++) begin
                b = 8'(c * 16 + j);
                errs = 0;
                for (int k = 0; k <= 10; k++) begin
                    if (tx_bit !== exp_bit(b, k)) errs++;
                    tick();
                end
                chk(errs == 0, "R5 frame sweep", errs, 0);
            end
            chk(underrun == 1 && tx_bit == 1, "R7 underrun after burst", underrun, 1);
            pulse_clr();
            rts = 1'b0;
            @(negedge clk);
            chk(cts == 0 && fifo_level == 0, "R8 release after burst", cts, 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule